// File: doc/BRIEF.md
# Barrel Thread Scheduler

This block is the front end of a barrel-style core that runs several hardware threads on one physical pipeline. It keeps a program counter and a memory-wait flag for each thread. On every clock it picks the thread that issues next, and it presents that thread's index and program counter. The index also selects the register bank that the pipeline uses for that instruction.

The decode stub reports on the instruction currently shown at the outputs. It reports whether the instruction is a load, which parks the thread until its data returns. It also reports whether the instruction is a taken branch, and the branch target. The memory stub returns data with a strobe tagged by thread index. The mode input selects one of two switching policies. In per-instruction mode, the block moves to a different thread after every issue, in a fixed rotation. In stall-switch mode, the same thread keeps issuing until it issues a load, which is the expensive stall.

Top module: `barrel_sched`

## Requirements
- R1: While reset is high, and on the first cycle after it, `iss_valid` is 0. Reset loads every program counter with `START_BASE + i*START_STRIDE`, marks every thread ready, and starts the rotation at thread 0. The first issue after reset is therefore thread 0 at its start address.
- R2: In per-instruction mode (`coarse_mode`=0), after thread t issues, the search for the next thread starts at t+1 modulo the thread count. The threads are served in ascending index order, and the order wraps.
- R3: In per-instruction mode, a waiting thread at the head of the search is skipped, and the first ready thread after it issues. When that thread issues, the search start moves past it.
- R4: An issued instruction with `dec_load`=1 parks its thread. That thread does not issue again until `ret_valid`=1 arrives with `ret_tid` equal to its index. The returned thread may issue on the cycle after the strobe.
- R5: When no thread is ready, `iss_valid` is 0 for that cycle. The decode inputs have no effect during such a bubble. The next search starts where the previous one started.
- R6: Without a branch, the issuing thread's program counter advances by one. With `dec_branch`=1, it loads `dec_target`. The program counters of the other threads stay unchanged.
- R7: In stall-switch mode (`coarse_mode`=1), a thread that issues without a load issues again on the next cycle. After it issues a load, the first ready thread after it, in ascending order, issues.
- R8: `iss_tid` names the thread whose program counter is on `iss_pc`. The same index selects the register bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coarse_mode | input | 1 | 0: switch thread after each issue; 1: switch only on a load |
| dec_load | input | 1 | The shown instruction is a memory load |
| dec_branch | input | 1 | The shown instruction is a taken branch |
| dec_target | input | PCW | Branch target for the shown instruction |
| ret_valid | input | 1 | Load data returned this cycle |
| ret_tid | input | TIDW | Thread that the returned data belongs to |
| iss_valid | output | 1 | A thread issues this cycle |
| iss_tid | output | TIDW | Issuing thread; also the register bank select |
| iss_pc | output | PCW | Program counter of the issuing thread |

## Verification
The assertions assume that the decode inputs describe the instruction shown on the outputs in the same cycle. They also assume that a return strobe never names the thread that is issuing, because an issuing thread cannot be parked. The table-driven stimulus keeps to these rules: each row sets the decode fields only for the thread shown, and sends returns only for parked threads. One row deliberately raises `dec_load` during a bubble, to show that this input is ignored while nothing issues. The rows that use stall-switch mode never change the mode in the middle of a row. This keeps the mode-dependent assertions tied to a single policy.

// File: rtl/bs_pkg.sv
`timescale 1ns/1ps
package bs_pkg;
  typedef enum logic {
    SW_PER_INSTR = 1'b0,
    SW_ON_STALL  = 1'b1
  } sw_mode_e;
endpackage

// File: rtl/bs_ctx.sv
`timescale 1ns/1ps
// Per-thread context: program counter and memory-wait flag.
// Next-state values are exported so the picker sees this edge's updates.
module bs_ctx #(
  parameter int unsigned NTHR         = 4,
  parameter int unsigned PCW          = 16,
  parameter int unsigned TIDW         = 2,
  parameter int unsigned START_BASE   = 256,
  parameter int unsigned START_STRIDE = 256
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      upd_en,
  input  logic [TIDW-1:0]           upd_tid,
  input  logic                      upd_load,
  input  logic                      upd_branch,
  input  logic [PCW-1:0]            upd_target,
  input  logic                      ret_valid,
  input  logic [TIDW-1:0]           ret_tid,
  output logic [NTHR-1:0][PCW-1:0]  pc_nx,
  output logic [NTHR-1:0]           ready_nx
);
  logic [NTHR-1:0][PCW-1:0] pc_q;
  logic [NTHR-1:0]          wait_q;
  logic [NTHR-1:0]          wait_nx;

  for (genvar g = 0; g < NTHR; g++) begin : g_thr
    logic hit_upd;
    logic hit_ret;

    assign hit_upd = upd_en && (upd_tid == TIDW'(g));
    assign hit_ret = ret_valid && (ret_tid == TIDW'(g));

    always_comb begin
      pc_nx[g] = pc_q[g];
      if (hit_upd) begin
        pc_nx[g] = upd_branch ? upd_target : pc_q[g] + PCW'(1);
      end
    end

    // a load issued by this thread wins over a stray return
    always_comb begin
      wait_nx[g] = wait_q[g];
      if (hit_ret) wait_nx[g] = 1'b0;
      if (hit_upd && upd_load) wait_nx[g] = 1'b1;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        pc_q[g]   <= PCW'(START_BASE + g * START_STRIDE);
        wait_q[g] <= 1'b0;
      end else begin
        pc_q[g]   <= pc_nx[g];
        wait_q[g] <= wait_nx[g];
      end
    end
  end

  assign ready_nx = ~wait_nx;
endmodule

// File: rtl/bs_pick.sv
`timescale 1ns/1ps
// Rotating-priority pick: first ready thread at or after 'start'.
module bs_pick #(
  parameter int unsigned NTHR = 4,
  parameter int unsigned TIDW = 2
) (
  input  logic [TIDW-1:0] start,
  input  logic [NTHR-1:0] ready,
  output logic            found,
  output logic [TIDW-1:0] pick
);
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = 0; k < NTHR; k++) begin
      int idx;
      idx = int'(start) + k;
      if (idx >= int'(NTHR)) idx = idx - int'(NTHR);
      if (!found && ready[idx]) begin
        found = 1'b1;
        pick  = TIDW'(idx);
      end
    end
  end
endmodule

// File: rtl/barrel_sched.sv
`timescale 1ns/1ps
module barrel_sched #(
  parameter int unsigned NTHR         = 4,
  parameter int unsigned PCW          = 16,
  parameter int unsigned START_BASE   = 256,
  parameter int unsigned START_STRIDE = 256,
  localparam int unsigned TIDW        = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            coarse_mode,
  input  logic            dec_load,
  input  logic            dec_branch,
  input  logic [PCW-1:0]  dec_target,
  input  logic            ret_valid,
  input  logic [TIDW-1:0] ret_tid,
  output logic            iss_valid,
  output logic [TIDW-1:0] iss_tid,
  output logic [PCW-1:0]  iss_pc
);
  import bs_pkg::*;

  localparam logic [TIDW-1:0] LAST_TID = TIDW'(NTHR - 1);

  sw_mode_e                 mode;
  logic [NTHR-1:0][PCW-1:0] pc_nx;
  logic [NTHR-1:0]          ready_nx;
  logic [TIDW-1:0]          start_q;
  logic [TIDW-1:0]          start_c;
  logic [TIDW-1:0]          after_cur;
  logic                     found;
  logic [TIDW-1:0]          pick;

  assign mode = sw_mode_e'(coarse_mode);

  bs_ctx #(
    .NTHR(NTHR), .PCW(PCW), .TIDW(TIDW),
    .START_BASE(START_BASE), .START_STRIDE(START_STRIDE)
  ) u_ctx (
    .clk        (clk),
    .rst        (rst),
    .upd_en     (iss_valid),
    .upd_tid    (iss_tid),
    .upd_load   (dec_load),
    .upd_branch (dec_branch),
    .upd_target (dec_target),
    .ret_valid  (ret_valid),
    .ret_tid    (ret_tid),
    .pc_nx      (pc_nx),
    .ready_nx   (ready_nx)
  );

  assign after_cur = (iss_tid == LAST_TID) ? '0 : iss_tid + TIDW'(1);

  // search origin: current thread on stall-switch, its successor otherwise,
  // and the previous origin after a bubble
  always_comb begin
    start_c = start_q;
    if (iss_valid) begin
      start_c = (mode == SW_ON_STALL) ? iss_tid : after_cur;
    end
  end

  bs_pick #(.NTHR(NTHR), .TIDW(TIDW)) u_pick (
    .start (start_c),
    .ready (ready_nx),
    .found (found),
    .pick  (pick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q   <= '0;
      iss_valid <= 1'b0;
      iss_tid   <= '0;
      iss_pc    <= '0;
    end else begin
      start_q   <= start_c;
      iss_valid <= found;
      iss_tid   <= pick;
      iss_pc    <= pc_nx[pick];
    end
  end
endmodule

// File: rtl/bs_chk.sv
`timescale 1ns/1ps
module bs_chk #(
  parameter int unsigned PCW  = 16,
  parameter int unsigned TIDW = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            coarse_mode,
  input logic            dec_load,
  input logic            dec_branch,
  input logic [PCW-1:0]  dec_target,
  input logic            iss_valid,
  input logic [TIDW-1:0] iss_tid,
  input logic [PCW-1:0]  iss_pc
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> !iss_valid);

  assert_load_parks_R4: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && dec_load) |=> !(iss_valid && iss_tid == $past(iss_tid)));

  assert_stay_on_thread_R7: assert property (@(posedge clk) disable iff (rst)
    (coarse_mode && iss_valid && !dec_load) |=> (iss_valid && iss_tid == $past(iss_tid)));

  assert_pc_step_R6: assert property (@(posedge clk) disable iff (rst)
    (coarse_mode && iss_valid && !dec_load && !dec_branch)
      |=> (iss_pc == $past(iss_pc) + PCW'(1)));

  assert_pc_branch_R6: assert property (@(posedge clk) disable iff (rst)
    (coarse_mode && iss_valid && !dec_load && dec_branch)
      |=> (iss_pc == $past(dec_target)));
endmodule

bind barrel_sched bs_chk #(.PCW(PCW), .TIDW(TIDW)) u_bs_chk (
  .clk         (clk),
  .rst         (rst),
  .coarse_mode (coarse_mode),
  .dec_load    (dec_load),
  .dec_branch  (dec_branch),
  .dec_target  (dec_target),
  .iss_valid   (iss_valid),
  .iss_tid     (iss_tid),
  .iss_pc      (iss_pc)
);

// File: tb/barrel_sched_bench.sv
`timescale 1ns/1ps
module barrel_sched_bench;
  localparam int NROW = 17;
  // row: {exp_v, exp_tid[1:0], exp_pc[15:0], mode, load, branch, target[15:0], ret_v, ret_tid[1:0]}
  localparam logic [40:0] VEC [NROW] = '{
    {1'b1, 2'd0, 16'h0100, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 2'd0}, // 0  R1 first issue
    {1'b1, 2'd1, 16'h0200, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 2'd0}, // 1  R2 t1 loads
    {1'b1, 2'd2, 16'h0300, 1'b0, 1'b0, 1'b1, 16'h0350, 1'b0, 2'd0}, // 2  R6 t2 branches
    {1'b1, 2'd3, 16'h0400, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 2'd0}, // 3  R2
    {1'b1, 2'd0, 16'h0101, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 2'd0}, // 4  R2 wrap, t0 loads
    {1'b1, 2'd2, 16'h0350, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 2'd1}, // 5  R3 skip t1; return t1
    {1'b1, 2'd3, 16'h0401, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 2'd0}, // 6  R3 t3 loads
    {1'b1, 2'd1, 16'h0201, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 2'd0}, // 7  R4 t1 back, loads
    {1'b1, 2'd2, 16'h0351, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 2'd0}, // 8  R6 t2 loads
    {1'b0, 2'd0, 16'h0000, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b1, 2'd3}, // 9  R5 bubble; stray load
    {1'b1, 2'd3, 16'h0402, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, 2'd0}, // 10 R5 no effect; stall mode
    {1'b1, 2'd3, 16'h0403, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b1, 2'd0}, // 11 R7 stays; return t0
    {1'b1, 2'd3, 16'h0404, 1'b1, 1'b1, 1'b0, 16'h0000, 1'b0, 2'd0}, // 12 R7 t3 loads
    {1'b1, 2'd0, 16'h0102, 1'b1, 1'b0, 1'b1, 16'h00AA, 1'b0, 2'd0}, // 13 R7 switch; branch
    {1'b1, 2'd0, 16'h00AA, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b1, 2'd1}, // 14 R6 target; return t1
    {1'b1, 2'd0, 16'h00AB, 1'b1, 1'b1, 1'b0, 16'h0000, 1'b0, 2'd0}, // 15 R8 t0 loads
    {1'b1, 2'd1, 16'h0202, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, 2'd0}  // 16 R7 first ready after t0
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        coarse_mode = 1'b0;
  logic        dec_load = 1'b0;
  logic        dec_branch = 1'b0;
  logic [15:0] dec_target = '0;
  logic        ret_valid = 1'b0;
  logic [1:0]  ret_tid = '0;
  logic        iss_valid;
  logic [1:0]  iss_tid;
  logic [15:0] iss_pc;

  int n_total = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  barrel_sched u_barrel_sched (
    .clk(clk), .rst(rst), .coarse_mode(coarse_mode),
    .dec_load(dec_load), .dec_branch(dec_branch), .dec_target(dec_target),
    .ret_valid(ret_valid), .ret_tid(ret_tid),
    .iss_valid(iss_valid), .iss_tid(iss_tid), .iss_pc(iss_pc)
  );

  function automatic string row_req(int i);
    case (i)
      0:           return "R1";
      1, 3, 4:     return "R2";
      5, 6:        return "R3";
      7:           return "R4";
      9, 10:       return "R5";
      2, 8, 14:    return "R6";
      15:          return "R8";
      default:     return "R7";
    endcase
  endfunction

  task automatic check_iss(string req, logic ev, logic [1:0] et, logic [15:0] ep);
    bit ok;
    n_total++;
    ok = (iss_valid === ev) && (!ev || (iss_tid === et && iss_pc === ep));
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual v=%0b tid=%0d pc=%h expected v=%0b tid=%0d pc=%h",
               req, iss_valid, iss_tid, iss_pc, ev, et, ep);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_total++;
      n_fail++;
      $display("FAIL R2 watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    check_iss("R1", 1'b0, 2'd0, 16'h0000);   // idle during reset
    rst = 1'b0;
    @(negedge clk);
    for (int i = 0; i < NROW; i++) begin
      logic [40:0] r;
      r = VEC[i];
      check_iss(row_req(i), r[40], r[39:38], r[37:22]);
      coarse_mode = r[21];
      dec_load    = r[20];
      dec_branch  = r[19];
      dec_target  = r[18:3];
      ret_valid   = r[2];
      ret_tid     = r[1:0];
      @(negedge clk);
    end
    // reset in mid-run clears parked threads and program counters (R1)
    coarse_mode = 1'b0;
    dec_load    = 1'b0;
    dec_branch  = 1'b0;
    ret_valid   = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check_iss("R1", 1'b0, 2'd0, 16'h0000);
    rst = 1'b0;
    @(negedge clk);
    for (int t = 0; t < 4; t++) begin
      check_iss("R1", 1'b1, 2'(t), 16'(16'h0100 * (t + 1)));
      @(negedge clk);
    end
    done = 1'b1;
    summary();
    $finish;
  end
endmodule